// File: doc/BRIEF.md
# Character Display Host Register Port

This block is the host side of an eight-digit dot-matrix character display. A processor reaches it through an 8-bit data bus, a five-bit address and active-low chip-select, write, read and flash-select strobes. Each access is steered to one of five storage areas: per-digit blink bits, a user-glyph index register, a user-glyph dot pattern RAM, the character code RAM and a control word. Each area takes its own slice of the data bus. Every stored value is presented in parallel to the scan logic, and the scan logic also has a private read port into the glyph pattern RAM.

The write strobe is asynchronous to the display clock. It passes through a synchronizer, and a write is committed on its rising edge. A synchronous active-high reset returns the registers to their defined state, with blank codes in every character slot. For a fixed number of clocks after reset the block refuses host accesses, and it shows this on a status output.

Top module: `chdisp_host_port`

## Requirements
- R1: With `fsel_n` low, a write sets `blink_mask[addr[2:0]]` to `wdata[0]`, whatever `addr[4:3]` is. `wdata[7:1]` is ignored and no other area changes.
- R2: With `fsel_n` high and `addr[4:3]`=00, a write loads the glyph index register from `wdata[UA_W-1:0]`. `addr[2:0]` is ignored.
- R3: With `fsel_n` high and `addr[4:3]`=01, a write stores `wdata[DOT_W-1:0]` into the pattern RAM at row `addr[2:0]` of the glyph selected by the index register. `scan_dots` returns the row chosen by `scan_sel`/`scan_row` one clock later.
- R4: With `fsel_n` high and `addr[4:3]`=11, a write stores all eight bits of `wdata` in character slot `addr[2:0]`. The slot appears as `char_codes[8*i+7:8*i]`, and bit 7 (the user-glyph flag) is kept intact.
- R5: With `fsel_n` high and `addr[4:3]`=10, a write loads `ctrl_word` from all eight bits of `wdata`. `addr[2:0]` is ignored.
- R6: A write takes place only on a low-to-high transition of `wr_n` while `cs_n` is low. The stored value changes on the second clock edge after the first edge that samples `wr_n` high. Holding `wr_n` low stores nothing, and so does a strobe with `cs_n` high.
- R7: Reset clears `blink_mask`, `ctrl_word` (0 means full brightness) and the glyph index register, and loads 20h into every character slot. The pattern RAM keeps its contents.
- R8: `lockout` is high during reset and for `LOCK_CYCLES` clocks after reset is released. Writes that would commit in that time are dropped.
- R9: A read with `cs_n` and `rd_n` low returns the addressed location on `rdata` one clock later, using the same decode as writes, with unused bits at zero. `rdata` is zero when no read is active or `lockout` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, commits on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| fsel_n | input | 1 | Selects blink bits when low |
| addr | input | 5 | Area select [4:3] and index [2:0] |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| lockout | output | 1 | Post-reset access block active |
| char_codes | output | 8*DIGITS | Character slots, slot i in bits [8i+7:8i] |
| blink_mask | output | DIGITS | Per-digit blink enables |
| ctrl_word | output | 8 | Control word |
| scan_sel | input | UA_W | Scan-side glyph index |
| scan_row | input | IDX_W | Scan-side glyph row |
| scan_dots | output | DOT_W | Registered scan-side row pattern |

## Verification
The bench builds the block with `LOCK_CYCLES` set to 8 and the other parameters at their defaults. With that window a whole synchronised write pulse fits inside the lockout, so the bench can show that a complete, well-formed write is dropped and that the window closes on the exact clock. The default glyph index width of four bits lets it place two glyphs at the same row and confirm that they do not alias.

// File: rtl/chdisp_pkg.sv
package chdisp_pkg;

  typedef enum logic [2:0] {
    AR_BLINK,
    AR_GINDEX,
    AR_GROW,
    AR_CHAR,
    AR_CTRL
  } area_e;

  // Flash select has priority over the two area bits.
  function automatic area_e area_decode(input logic fsel_n, input logic a4, input logic a3);
    if (!fsel_n) return AR_BLINK;
    case ({a4, a3})
      2'b00:   return AR_GINDEX;
      2'b01:   return AR_GROW;
      2'b11:   return AR_CHAR;
      default: return AR_CTRL;
    endcase
  endfunction

endpackage

// File: rtl/chdisp_strobe_sync.sv
module chdisp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '1;
    else     sh_q <= {sh_q[STAGES-1:0], strobe_n};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/chdisp_lockout.sv
module chdisp_lockout #(
  parameter int CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  output logic lock
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lock  <= 1'b1;
    end else if (lock) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(CYCLES - 1)) lock <= 1'b0;
    end
  end
endmodule

// File: rtl/chdisp_glyph_ram.sv
module chdisp_glyph_ram #(
  parameter int AW = 7,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] h_addr,
  output logic [DW-1:0] h_data,
  input  logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    s_data <= mem[s_addr];
  end

  assign h_data = mem[h_addr];
endmodule

// File: rtl/chdisp_host_port.sv
module chdisp_host_port
  import chdisp_pkg::*;
#(
  parameter int         IDX_W       = 3,
  parameter int         UA_W        = 4,
  parameter int         DOT_W       = 5,
  parameter int         LOCK_CYCLES = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] BLANK_CODE  = 8'h20,
  localparam int        DIGITS      = 1 << IDX_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  wr_n,
  input  logic                  rd_n,
  input  logic                  fsel_n,
  input  logic [4:0]            addr,
  input  logic [7:0]            wdata,
  output logic [7:0]            rdata,
  output logic                  lockout,
  output logic [DIGITS*8-1:0]   char_codes,
  output logic [DIGITS-1:0]     blink_mask,
  output logic [7:0]            ctrl_word,
  input  logic [UA_W-1:0]       scan_sel,
  input  logic [IDX_W-1:0]      scan_row,
  output logic [DOT_W-1:0]      scan_dots
);
  localparam int RAM_AW = UA_W + IDX_W;

  logic                    wr_rise;
  logic                    lock;
  logic                    commit;
  area_e                   area;
  logic [IDX_W-1:0]        idx;
  logic [UA_W-1:0]         gidx_q;
  logic [DIGITS-1:0][7:0]  chars_q;
  logic [DIGITS-1:0]       blink_q;
  logic [7:0]              ctrl_q;
  logic [DOT_W-1:0]        host_dots;
  logic [7:0]              rsel;

  chdisp_strobe_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk), .rst(rst), .strobe_n(wr_n), .rise(wr_rise)
  );

  chdisp_lockout #(.CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .lock(lock)
  );

  assign area   = area_decode(fsel_n, addr[4], addr[3]);
  assign idx    = addr[IDX_W-1:0];
  assign commit = wr_rise & ~cs_n & ~lock;

  chdisp_glyph_ram #(.AW(RAM_AW), .DW(DOT_W)) u_glyph (
    .clk   (clk),
    .we    (commit && area == AR_GROW),
    .waddr ({gidx_q, idx}),
    .wdata (wdata[DOT_W-1:0]),
    .h_addr({gidx_q, idx}),
    .h_data(host_dots),
    .s_addr({scan_sel, scan_row}),
    .s_data(scan_dots)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      blink_q <= '0;
      ctrl_q  <= '0;
      gidx_q  <= '0;
      chars_q <= {DIGITS{BLANK_CODE}};
    end else if (commit) begin
      case (area)
        AR_BLINK:  blink_q[idx] <= wdata[0];
        AR_GINDEX: gidx_q       <= wdata[UA_W-1:0];
        AR_CHAR:   chars_q[idx] <= wdata;
        AR_CTRL:   ctrl_q       <= wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rsel = '0;
    case (area)
      AR_BLINK:  rsel[0]         = blink_q[idx];
      AR_GINDEX: rsel[UA_W-1:0]  = gidx_q;
      AR_GROW:   rsel[DOT_W-1:0] = host_dots;
      AR_CHAR:   rsel            = chars_q[idx];
      default:   rsel            = ctrl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                         rdata <= '0;
    else if (!cs_n && !rd_n && !lock) rdata <= rsel;
    else                             rdata <= '0;
  end

  assign lockout    = lock;
  assign char_codes = chars_q;
  assign blink_mask = blink_q;
  assign ctrl_word  = ctrl_q;
endmodule

// File: rtl/chdisp_host_port_chk.sv
module chdisp_host_port_chk #(
  parameter int         DIGITS     = 8,
  parameter logic [7:0] BLANK_CODE = 8'h20
) (
  input logic                clk,
  input logic                rst,
  input logic                cs_n,
  input logic                rd_n,
  input logic                fsel_n,
  input logic [7:0]          rdata,
  input logic                lockout,
  input logic [DIGITS*8-1:0] char_codes,
  input logic [DIGITS-1:0]   blink_mask,
  input logic [7:0]          ctrl_word
);
  // R7
  reset_vals_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl_word == 8'h00 && blink_mask == '0 &&
                    char_codes == {DIGITS{BLANK_CODE}}));

  // R8
  lock_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lockout);

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(lockout) && !$past(rst)) |->
      ($stable(char_codes) && $stable(ctrl_word) && $stable(blink_mask)));

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n || rd_n || lockout) |-> rdata == 8'h00);

  // R6
  cs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cs_n) && !$past(rst)) |->
      ($stable(char_codes) && $stable(ctrl_word) && $stable(blink_mask)));

  // R1
  blink_iso_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(fsel_n) && !$past(rst)) |-> ($stable(char_codes) && $stable(ctrl_word)));
endmodule

bind chdisp_host_port chdisp_host_port_chk #(
  .DIGITS(DIGITS), .BLANK_CODE(BLANK_CODE)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .fsel_n(fsel_n),
  .rdata(rdata), .lockout(lockout), .char_codes(char_codes),
  .blink_mask(blink_mask), .ctrl_word(ctrl_word)
);

// File: tb/chdisp_host_port_tb.sv
module chdisp_host_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK       = 8;
  localparam int DIGITS     = 8;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, fsel_n = 1'b1;
  logic [4:0]          addr = '0;
  logic [7:0]          wdata = '0;
  logic [7:0]          rdata;
  logic                lockout;
  logic [DIGITS*8-1:0] char_codes;
  logic [DIGITS-1:0]   blink_mask;
  logic [7:0]          ctrl_word;
  logic [3:0]          scan_sel = '0;
  logic [2:0]          scan_row = '0;
  logic [4:0]          scan_dots;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chdisp_host_port #(.LOCK_CYCLES(LOCK)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .fsel_n(fsel_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .lockout(lockout), .char_codes(char_codes), .blink_mask(blink_mask),
    .ctrl_word(ctrl_word), .scan_sel(scan_sel), .scan_row(scan_row),
    .scan_dots(scan_dots)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_access(input logic fs, input logic [4:0] a, input logic [7:0] d);
    fsel_n = fs; addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic rd_access(input logic fs, input logic [4:0] a, output logic [7:0] d);
    fsel_n = fs; addr = a; cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    d = rdata;
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic t_reset_lockout;
    logic [7:0] r;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 lockout in reset", 64'(lockout), 64'd1);
    rst = 1'b0;
    wr_access(1'b1, 5'b10_000, 8'hA5);
    chk("R8 lockout mid-window", 64'(lockout), 64'd1);
    chk("R8 write in window dropped", 64'(ctrl_word), 64'h00);
    rd_access(1'b1, 5'b11_000, r);
    chk("R9 read in window zero", 64'(r), 64'h00);
    chk("R8 lockout last cycle", 64'(lockout), 64'd1);
    @(negedge clk);
    chk("R8 lockout released", 64'(lockout), 64'd0);
    chk("R7 chars blank", char_codes, {DIGITS{8'h20}});
    chk("R7 blink clear", 64'(blink_mask), 64'h0);
    chk("R7 ctrl clear", 64'(ctrl_word), 64'h0);
    rd_access(1'b1, 5'b00_000, r);
    chk("R7 glyph index clear", 64'(r), 64'h0);
    chk("R9 idle rdata zero", 64'(rdata), 64'h0);
  endtask

  task automatic t_blink;
    logic [7:0] r;
    wr_access(1'b0, 5'b11_010, 8'hFE);
    chk("R1 D0=0 ignores upper bits", 64'(blink_mask), 64'h00);
    wr_access(1'b0, 5'b11_010, 8'h01);
    chk("R1 blink set", 64'(blink_mask), 64'h04);
    chk("R1 chars untouched", char_codes, {DIGITS{8'h20}});
    chk("R1 ctrl untouched", 64'(ctrl_word), 64'h00);
    rd_access(1'b0, 5'b00_010, r);
    chk("R9 blink read", 64'(r), 64'h01);
    rd_access(1'b0, 5'b00_011, r);
    chk("R9 blink read other", 64'(r), 64'h00);
  endtask

  task automatic t_glyph;
    logic [7:0] r;
    wr_access(1'b1, 5'b00_101, 8'hF6);
    rd_access(1'b1, 5'b00_111, r);
    chk("R2 glyph index low bits", 64'(r), 64'h06);
    wr_access(1'b1, 5'b01_011, 8'hEB);
    rd_access(1'b1, 5'b01_011, r);
    chk("R3 row read back", 64'(r), 64'h0B);
    wr_access(1'b1, 5'b00_000, 8'h02);
    wr_access(1'b1, 5'b01_011, 8'h15);
    scan_sel = 4'd6; scan_row = 3'd3;
    @(negedge clk);
    chk("R3 scan glyph 6", 64'(scan_dots), 64'h0B);
    scan_sel = 4'd2;
    @(negedge clk);
    chk("R3 scan glyph 2", 64'(scan_dots), 64'h15);
  endtask

  task automatic t_char_ctrl;
    logic [7:0] r;
    wr_access(1'b1, 5'b11_000, 8'h41);
    wr_access(1'b1, 5'b11_111, 8'h85);
    chk("R4 slot 0", 64'(char_codes[7:0]), 64'h41);
    chk("R4 slot 7 flag kept", 64'(char_codes[63:56]), 64'h85);
    chk("R4 slot 3 blank", 64'(char_codes[31:24]), 64'h20);
    rd_access(1'b1, 5'b11_111, r);
    chk("R9 char read", 64'(r), 64'h85);
    wr_access(1'b1, 5'b10_111, 8'h3C);
    chk("R5 ctrl load", 64'(ctrl_word), 64'h3C);
    rd_access(1'b1, 5'b10_001, r);
    chk("R9 ctrl read", 64'(r), 64'h3C);
  endtask

  task automatic t_strobe;
    fsel_n = 1'b1; addr = 5'b10_000; wdata = 8'h77; cs_n = 1'b0; wr_n = 1'b0;
    repeat (5) @(negedge clk);
    chk("R6 low strobe stores nothing", 64'(ctrl_word), 64'h3C);
    wr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R6 not yet committed", 64'(ctrl_word), 64'h3C);
    @(negedge clk);
    chk("R6 committed on schedule", 64'(ctrl_word), 64'h77);
    cs_n = 1'b1;
    @(negedge clk);
    wdata = 8'h11; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 cs_n high blocks write", 64'(ctrl_word), 64'h77);
  endtask

  task automatic t_rereset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R8 lockout after rereset", 64'(lockout), 64'd1);
    repeat (LOCK) @(negedge clk);
    chk("R8 lockout ends", 64'(lockout), 64'd0);
    chk("R7 chars blank again", char_codes, {DIGITS{8'h20}});
    chk("R7 ctrl clear again", 64'(ctrl_word), 64'h0);
    chk("R7 blink clear again", 64'(blink_mask), 64'h0);
    scan_sel = 4'd6; scan_row = 3'd3;
    @(negedge clk);
    chk("R7 pattern RAM kept", 64'(scan_dots), 64'h0B);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    t_reset_lockout();
    t_blink();
    t_glyph();
    t_char_ctrl();
    t_strobe();
    t_rereset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule